// File: doc/BRIEF.md
# PLL Control Register Interlock Block

This block is the byte-wide register front end of a clock generator's phase-locked loop. It holds a control register, a bandwidth control register and a programming register. A small synchronous bus with address, write strobe, read strobe, write data and registered read data reaches all three. The block does not simply store bytes. Each write is filtered by conditions read live from the other registers, so software cannot put the loop into an unsafe state. For example, software cannot retune the loop while it runs, and cannot switch the bus clock onto a loop that is off or has no range set.

The block takes a lock indication and an acquisition indication from the lock detector. It raises a flag when the lock state changes in automatic mode, and it asks for an interrupt when that flag and the enable are both set. It drives the multiplier, the VCO range and the loop-enable to the loop. It also drives a select line to the clock mux, which picks the oscillator clock divided by two or the VCO clock divided by two.

Top module: `pll_regs_interlock`

## Requirements
- R1: After reset, a read of the control register (0x5C) returns 0x0F, a read of the bandwidth register (0x5D) returns 0x0F, and a read of the programming register (0x5E) returns 0x66. Outputs irq and bus_clk_sel are 0.
- R2: Control register fields are: interrupt enable at bit 7, PLL flag at bit 6, loop-on at bit 5, bus-clock-select at bit 4. Bandwidth register fields are: automatic mode at bit 7, lock at bit 6, acquisition at bit 5, crystal-loss-detect at bit 4. Bits 3..0 of both registers are reserved: they read 1 and ignore writes.
- R3: While automatic mode is 0, the interrupt enable is held at 0 and cannot be written. In the same mode the PLL flag is never set, and the flag and lock bits read 0.
- R4: While automatic mode is 1, the acquisition bit follows the acq_in input and ignores writes. While automatic mode is 0, the acquisition bit is written from bit 5.
- R5: While loop-on is 0, or the VCO range field (programming bits 3..0) is 0, bus-clock-select is forced to 0 and cannot be written. A write is judged against the loop-on and range values stored before that write.
- R6: While loop-on is 1, writes to the programming register (multiplier in bits 7..4, VCO range in bits 3..0) are ignored.
- R7: While bus-clock-select is 1, loop-on stays at 1 and cannot be written to 0.
- R8: In automatic mode, any change of the synchronised lock input sets the PLL flag. A read of the control register followed by a write to it clears the flag. If a set and a clear fall in the same cycle, the set wins. A write to the control register with no read of it since the last such write leaves the flag alone.
- R9: The output irq is 1 exactly when the PLL flag and the interrupt enable are both 1.
- R10: The crystal-loss-detect bit is a plain read/write bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| lock_in | input | 1 | Lock detector status |
| acq_in | input | 1 | Acquisition status from the loop |
| irq | output | 1 | Interrupt request |
| bus_clk_sel | output | 1 | 1 selects the VCO clock / 2, 0 the oscillator clock / 2 |
| pll_on | output | 1 | Loop enable |
| mult | output | 4 | Multiplier field |
| vco_range | output | 4 | VCO range field |

## Verification
The flag can be set by a lock change and cleared by a read-then-write sequence in the same cycle. The bench provokes this by arming the clear with a control read. It then toggles lock_in one cycle before the clearing write, so that the synchronised change and the write meet at one clock edge. The expected result is that irq stays 1, because the set wins. Loop-on and bus-clock-select interlocks also act on the same write. The bench judges them by writing both bits together and checking that bus-clock-select uses the stored loop-on value and not the value being written.

// File: rtl/pll_regs_pkg.sv
package pll_regs_pkg;
  localparam int REG_W   = 8;
  localparam int FIELD_W = 4;
  // control register bit positions
  localparam int C_IE   = 7;
  localparam int C_FLAG = 6;
  localparam int C_ON   = 5;
  localparam int C_BCS  = 4;
  // bandwidth register bit positions
  localparam int B_AUTO = 7;
  localparam int B_LOCK = 6;
  localparam int B_ACQ  = 5;
  localparam int B_XLD  = 4;
  localparam logic [FIELD_W-1:0] RSVD_READ  = '1;
  localparam logic [FIELD_W-1:0] MULT_RST   = 4'h6;
  localparam logic [FIELD_W-1:0] RANGE_RST  = 4'h6;
endpackage

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
  import pll_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic             rd_ctrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             auto_mode,
  input  logic             range_zero,
  input  logic             lock_chg,
  output logic             ie,
  output logic             flag,
  output logic             loop_on,
  output logic             bcs
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie      <= 1'b0;
      flag    <= 1'b0;
      loop_on <= 1'b0;
      bcs     <= 1'b0;
      armed   <= 1'b0;
    end else begin
      // interrupt enable only lives in automatic mode
      if (!auto_mode)   ie <= 1'b0;
      else if (wr_ctrl) ie <= wdata[C_IE];

      // loop-on is pinned while the bus clock runs from the VCO
      if (wr_ctrl && !bcs) loop_on <= wdata[C_ON];

      // clock select judged against the stored loop-on and range
      if (!loop_on || range_zero) bcs <= 1'b0;
      else if (wr_ctrl)           bcs <= wdata[C_BCS];

      // read-then-write clear, set has priority
      if (rd_ctrl)      armed <= 1'b1;
      else if (wr_ctrl) armed <= 1'b0;

      if (auto_mode && lock_chg)   flag <= 1'b1;
      else if (wr_ctrl && armed)   flag <= 1'b0;
    end
  end

  p_ie_manual_r3: assert property (@(posedge clk) disable iff (rst)
    !auto_mode |=> !ie);
  p_bcs_needs_on_r5: assert property (@(posedge clk) disable iff (rst)
    bcs |-> loop_on);
  p_on_held_r7: assert property (@(posedge clk) disable iff (rst)
    bcs |=> loop_on);
  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    (auto_mode && lock_chg) |=> flag);
  p_flag_quiet_manual_r3: assert property (@(posedge clk) disable iff (rst)
    (!auto_mode && !flag) |=> !flag);
endmodule

// File: rtl/pll_bw_reg.sv
module pll_bw_reg
  import pll_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_bw,
  input  logic [REG_W-1:0] wdata,
  input  logic             acq_in,
  output logic             auto_mode,
  output logic             acq,
  output logic             xld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      auto_mode <= 1'b0;
      acq       <= 1'b0;
      xld       <= 1'b0;
    end else begin
      if (wr_bw) begin
        auto_mode <= wdata[B_AUTO];
        xld       <= wdata[B_XLD];
      end
      if (auto_mode)  acq <= acq_in;
      else if (wr_bw) acq <= wdata[B_ACQ];
    end
  end

  p_acq_tracks_r4: assert property (@(posedge clk) disable iff (rst)
    auto_mode |=> (acq == $past(acq_in)));
endmodule

// File: rtl/pll_prog_reg.sv
module pll_prog_reg
  import pll_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_prog,
  input  logic [REG_W-1:0]   wdata,
  input  logic               loop_on,
  output logic [FIELD_W-1:0] mult,
  output logic [FIELD_W-1:0] vco_range
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mult      <= MULT_RST;
      vco_range <= RANGE_RST;
    end else if (wr_prog && !loop_on) begin
      mult      <= wdata[REG_W-1 -: FIELD_W];
      vco_range <= wdata[FIELD_W-1:0];
    end
  end

  p_prog_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    loop_on |=> $stable({mult, vco_range}));
endmodule

// File: rtl/pll_regs_interlock.sv
module pll_regs_interlock
  import pll_regs_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'h5C,
  parameter logic [7:0]  BW_ADDR   = 8'h5D,
  parameter logic [7:0]  PROG_ADDR = 8'h5E
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  input  logic               lock_in,
  input  logic               acq_in,
  output logic               irq,
  output logic               bus_clk_sel,
  output logic               pll_on,
  output logic [FIELD_W-1:0] mult,
  output logic [FIELD_W-1:0] vco_range
);
  logic sel_ctrl, sel_bw, sel_prog;
  logic lock_q, lock_prev, lock_chg;
  logic ie, flag, auto_mode, acq, xld;
  logic [REG_W-1:0] rd_mux;

  assign sel_ctrl = (addr == CTRL_ADDR[ADDR_W-1:0]);
  assign sel_bw   = (addr == BW_ADDR[ADDR_W-1:0]);
  assign sel_prog = (addr == PROG_ADDR[ADDR_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q    <= 1'b0;
      lock_prev <= 1'b0;
    end else begin
      lock_q    <= lock_in;
      lock_prev <= lock_q;
    end
  end
  assign lock_chg = lock_q ^ lock_prev;

  pll_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst),
    .wr_ctrl(wr_en && sel_ctrl), .rd_ctrl(rd_en && sel_ctrl),
    .wdata(wdata), .auto_mode(auto_mode),
    .range_zero(vco_range == '0), .lock_chg(lock_chg),
    .ie(ie), .flag(flag), .loop_on(pll_on), .bcs(bus_clk_sel)
  );

  pll_bw_reg u_bw (
    .clk(clk), .rst(rst), .wr_bw(wr_en && sel_bw), .wdata(wdata),
    .acq_in(acq_in), .auto_mode(auto_mode), .acq(acq), .xld(xld)
  );

  pll_prog_reg u_prog (
    .clk(clk), .rst(rst), .wr_prog(wr_en && sel_prog), .wdata(wdata),
    .loop_on(pll_on), .mult(mult), .vco_range(vco_range)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)
      rd_mux = {ie, flag && auto_mode, pll_on, bus_clk_sel, RSVD_READ};
    else if (sel_bw)
      rd_mux = {auto_mode, lock_q && auto_mode, acq, xld, RSVD_READ};
    else if (sel_prog)
      rd_mux = {mult, vco_range};
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign irq = flag && ie;

  p_bcs_needs_range_r5: assert property (@(posedge clk) disable iff (rst)
    bus_clk_sel |-> (vco_range != '0));
endmodule

// File: tb/pll_regs_interlock_tb.sv
module pll_regs_interlock_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       lock_in = 1'b0, acq_in = 1'b0;
  logic       irq, bus_clk_sel, pll_on;
  logic [3:0] mult, vco_range;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h5C, A_BW = 8'h5D, A_PROG = 8'h5E;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_regs_interlock u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .lock_in(lock_in), .acq_in(acq_in),
    .irq(irq), .bus_clk_sel(bus_clk_sel), .pll_on(pll_on),
    .mult(mult), .vco_range(vco_range)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_CTRL, d); chk("R1 ctrl reset", d, 8'h0F);
    rd(A_BW, d);   chk("R1 bw reset", d, 8'h0F);
    rd(A_PROG, d); chk("R1 prog reset", d, 8'h66);
    chk("R1 irq/bcs reset", {6'd0, irq, bus_clk_sel}, 8'h00);
  endtask

  task automatic t_manual();
    logic [7:0] d;
    wr(A_CTRL, 8'hF0);
    rd(A_CTRL, d); chk("R3 R5 R2 manual ctrl write", d, 8'h2F);
    wr(A_CTRL, 8'h00);
    lock_in = 1'b1; idle(4);
    rd(A_CTRL, d); chk("R3 no flag in manual", d, 8'h0F);
    rd(A_BW, d);   chk("R3 lock reads 0 in manual", d, 8'h0F);
    lock_in = 1'b0; idle(4);
  endtask

  task automatic t_prog_interlocks();
    logic [7:0] d;
    wr(A_PROG, 8'hA3);
    rd(A_PROG, d); chk("R6 prog write when off", d, 8'hA3);
    wr(A_CTRL, 8'h20);
    wr(A_PROG, 8'h55);
    rd(A_PROG, d); chk("R6 prog frozen when on", d, 8'hA3);
    wr(A_CTRL, 8'h30);
    rd(A_CTRL, d); chk("R5 bcs set when on and range nonzero", d, 8'h3F);
    chk("R5 bus_clk_sel port", {7'd0, bus_clk_sel}, 8'h01);
    wr(A_CTRL, 8'h00);
    rd(A_CTRL, d); chk("R7 loop-on held by bcs", d, 8'h2F);
    wr(A_CTRL, 8'h00);
    rd(A_CTRL, d); chk("R7 loop-on released", d, 8'h0F);
    wr(A_PROG, 8'h90);
    wr(A_CTRL, 8'h20);
    wr(A_CTRL, 8'h30);
    rd(A_CTRL, d); chk("R5 bcs forced 0 with range 0", d, 8'h2F);
    wr(A_CTRL, 8'h00);
    wr(A_PROG, 8'h93);
    rd(A_PROG, d); chk("R6 prog writable again", {mult, vco_range}, 8'h93);
  endtask

  task automatic t_bandwidth();
    logic [7:0] d;
    wr(A_BW, 8'h3F);
    rd(A_BW, d); chk("R4 R10 R2 manual acq/xld write", d, 8'h3F);
    acq_in = 1'b0;
    wr(A_BW, 8'hA0);
    idle(1);
    rd(A_BW, d); chk("R4 acq follows input 0", d, 8'h8F);
    acq_in = 1'b1; idle(2);
    wr(A_BW, 8'h80);
    rd(A_BW, d); chk("R4 acq read-only in auto", d, 8'hAF);
    wr(A_BW, 8'h90);
    rd(A_BW, d); chk("R10 xld set in auto", d, 8'hBF);
  endtask

  task automatic t_flag();
    logic [7:0] d;
    wr(A_CTRL, 8'h80);
    lock_in = 1'b1; idle(4);
    chk("R9 irq with flag and enable", {7'd0, irq}, 8'h01);
    rd(A_BW, d);   chk("R2 lock bit in auto", d & 8'h40, 8'h40);
    rd(A_CTRL, d); chk("R8 flag set on lock change", d, 8'hCF);
    wr(A_CTRL, 8'h80);
    rd(A_CTRL, d); chk("R8 flag cleared by read then write", d, 8'h8F);
    wr(A_CTRL, 8'h80);
    lock_in = 1'b0; idle(4);
    wr(A_CTRL, 8'h80);
    chk("R8 write without read keeps flag", {7'd0, irq}, 8'h01);
    rd(A_CTRL, d);
    wr(A_CTRL, 8'h80);
    chk("R8 flag cleared again", {7'd0, irq}, 8'h00);
    rd(A_CTRL, d);
    @(negedge clk); lock_in = 1'b1;
    wr(A_CTRL, 8'h80);
    chk("R8 set wins over same-cycle clear", {7'd0, irq}, 8'h01);
    wr(A_CTRL, 8'h00);
    chk("R9 no irq with enable 0", {7'd0, irq}, 8'h00);
    wr(A_BW, 8'h00);
    rd(A_CTRL, d); chk("R3 leaving auto drops enable and flag read", d, 8'h0F);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_manual();
    t_prog_interlocks();
    t_bandwidth();
    t_flag();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule